// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Aligner

This block sits between a 32-bit core and a data memory that is addressed by whole words. It turns every core access into a word address. For a load it picks the addressed byte, halfword or word out of the memory word and extends it to the full width, either with zeros or with its own top bit. For a store it builds a complete write word. The new bytes go into their lanes and every other lane keeps the value of the current memory word, so a word-addressed array can take byte and halfword stores as a read-modify-write.

Requests enter on a valid/ready channel. The read port of the memory is outside the block and is assumed to be combinational: the block presents `mem_raddr` from the request in the same cycle and expects the current word of that address on `mem_rdata` in the same cycle. Each accepted request produces one registered response on a second valid/ready channel, one cycle later. Back-pressure works as follows. While a response is pending and `rsp_ready` is low, `req_ready` is low and the response holds still. When `rsp_ready` is high, a new request may be accepted in the same cycle that the old response is taken. The memory write enable is a plain one-cycle pulse that goes out together with the response of a store.

Top module: `lsu_lane_align`

## Requirements
- R1: The byte address is `req_base` plus `req_imm` sign-extended from 12 bits. `mem_raddr` shows the byte address with its two low bits dropped while a request is presented, and a store writes to that same word address on `mem_waddr`.
- R2: A load of size code 0 (byte) returns the byte at offset k (bits 8k+7:8k) in bits 7:0. If `req_sext` is 1, bits 31:8 are copies of its bit 7; otherwise they are zero. This holds for offsets 0 to 3.
- R3: A load of size code 1 (halfword) at offset 0, 1 or 2 returns bits 8k+15:8k in bits 15:0. Bits 31:16 are copies of bit 15 if `req_sext` is 1, and zero otherwise.
- R4: A load of size code 2 (word) at offset 0 returns the whole memory word, whatever the value of `req_sext`.
- R5: A store writes the word ((wdata AND M) << 8k) OR (old AND NOT (M << 8k)), where M is 0xFF, 0xFFFF or 0xFFFFFFFF for byte, halfword or word and old is `mem_rdata`.
- R6: A halfword at offset 3, or a word at any nonzero offset, sets `rsp_misalign`. Such a load returns zero data, and such a store raises no `mem_we`.
- R7: `mem_we` is high for exactly the one cycle after each accepted aligned store. It is never high for a load.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` and `rsp_misalign` stay stable. A response is taken, and a new request can be accepted, in any cycle where `rsp_ready` is high.
- R9: After reset, `rsp_valid` and `mem_we` are low and `req_ready` is high.
- R10: Size code 3 behaves exactly like size code 2 (word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_sext | input | 1 | Load result: 1 sign-extend, 0 zero-extend |
| req_base | input | 32 | Base register value |
| req_imm | input | 12 | Signed address offset |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_raddr | output | 30 | Word address of the presented request |
| mem_rdata | input | 32 | Current memory word at mem_raddr, same cycle |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_data | output | 32 | Extended load result (zero for stores) |
| rsp_misalign | output | 1 | Access crossed the word boundary |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_waddr | output | 30 | Word address for the write |
| mem_wdata | output | 32 | Merged full write word |

## Verification
The assertions assume that `mem_raddr`, sampled in the accept cycle, is the address of the request being accepted. This holds only if the request fields stay stable while `req_valid` is high and `req_ready` is low. The bench therefore holds every request field unchanged until the accepting edge. It also keeps `mem_rdata` at the value of the modelled current word through that edge, because the block assumes a combinational memory read. Random requests cover every size code, offset, sign mode and immediate sign. Directed cases add the halfword at offset 3, words at nonzero offsets, size code 3, and a stalled response with a second request waiting behind it.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  // Number of bytes an access touches; word codes map to a full lane set.
  function automatic int unsigned size_nbytes(acc_size_e s, int unsigned lanes);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return lanes;
    endcase
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic [XLEN-1:0]                 base,
  input  logic [IMM_W-1:0]                imm,
  input  acc_size_e                       size,
  output logic [XLEN-$clog2(XLEN/8)-1:0]  waddr,
  output logic [$clog2(XLEN/8)-1:0]       ofs,
  output logic                            misalign
);
  localparam int LANES = XLEN / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [XLEN-1:0] byte_addr;
  int unsigned     span_end;

  always_comb begin
    byte_addr = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    waddr     = byte_addr[XLEN-1:OFS_W];
    ofs       = byte_addr[OFS_W-1:0];
    span_end  = int'(ofs) + size_nbytes(size, LANES);
    misalign  = (span_end > LANES);
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]            rdata,
  input  logic [$clog2(XLEN/8)-1:0]  ofs,
  input  acc_size_e                  size,
  input  logic                       sext,
  output logic [XLEN-1:0]            data
);
  localparam int LANES = XLEN / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [XLEN-1:0]  shifted;
  logic [OFS_W-1:0] top_lane;
  logic             sign_bit;
  logic [7:0]       fill;
  int unsigned      nbytes;

  always_comb begin
    shifted  = rdata >> {ofs, 3'b000};
    nbytes   = size_nbytes(size, LANES);
    top_lane = OFS_W'(nbytes - 1);
    sign_bit = shifted[{top_lane, 3'b111}];
    fill     = (sext && sign_bit) ? 8'hFF : 8'h00;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data[8*g +: 8] = (g < nbytes) ? shifted[8*g +: 8] : fill;
  end
endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]            wdata,
  input  logic [XLEN-1:0]            old_word,
  input  logic [$clog2(XLEN/8)-1:0]  ofs,
  input  acc_size_e                  size,
  output logic [XLEN-1:0]            merged
);
  localparam int LANES = XLEN / 8;

  logic [XLEN-1:0] placed;
  int unsigned     first_lane;
  int unsigned     past_lane;

  always_comb begin
    placed     = wdata << {ofs, 3'b000};
    first_lane = int'(ofs);
    past_lane  = first_lane + size_nbytes(size, LANES);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (g >= first_lane) && (g < past_lane);
    assign merged[8*g +: 8] = hit ? placed[8*g +: 8] : old_word[8*g +: 8];
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_store,
  input  logic [1:0]                      req_size,
  input  logic                            req_sext,
  input  logic [XLEN-1:0]                 req_base,
  input  logic [IMM_W-1:0]                req_imm,
  input  logic [XLEN-1:0]                 req_wdata,
  output logic [XLEN-$clog2(XLEN/8)-1:0]  mem_raddr,
  input  logic [XLEN-1:0]                 mem_rdata,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [XLEN-1:0]                 rsp_data,
  output logic                            rsp_misalign,
  output logic                            mem_we,
  output logic [XLEN-$clog2(XLEN/8)-1:0]  mem_waddr,
  output logic [XLEN-1:0]                 mem_wdata
);
  localparam int LANES = XLEN / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int WA_W  = XLEN - OFS_W;

  acc_size_e        size_e;
  logic [WA_W-1:0]  word_addr;
  logic [OFS_W-1:0] lane_ofs;
  logic             mis;
  logic [XLEN-1:0]  load_val;
  logic [XLEN-1:0]  store_val;
  logic             accept;

  assign size_e = acc_size_e'(req_size);

  lsu_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
    .base     (req_base),
    .imm      (req_imm),
    .size     (size_e),
    .waddr    (word_addr),
    .ofs      (lane_ofs),
    .misalign (mis)
  );

  lsu_load_extract #(.XLEN(XLEN)) u_load (
    .rdata (mem_rdata),
    .ofs   (lane_ofs),
    .size  (size_e),
    .sext  (req_sext),
    .data  (load_val)
  );

  lsu_store_merge #(.XLEN(XLEN)) u_store (
    .wdata    (req_wdata),
    .old_word (mem_rdata),
    .ofs      (lane_ofs),
    .size     (size_e),
    .merged   (store_val)
  );

  assign mem_raddr = word_addr;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  // Response and write stage: one register level after acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_misalign <= 1'b0;
      mem_we       <= 1'b0;
      mem_waddr    <= '0;
      mem_wdata    <= '0;
    end else begin
      mem_we <= accept && req_store && !mis;
      if (accept) begin
        rsp_valid    <= 1'b1;
        rsp_misalign <= mis;
        rsp_data     <= (req_store || mis) ? '0 : load_val;
        mem_waddr    <= word_addr;
        mem_wdata    <= store_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int XLEN = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            req_store,
  input logic [XLEN-$clog2(XLEN/8)-1:0]  mem_raddr,
  input logic                            rsp_valid,
  input logic                            rsp_ready,
  input logic [XLEN-1:0]                 rsp_data,
  input logic                            rsp_misalign,
  input logic                            mem_we,
  input logic [XLEN-$clog2(XLEN/8)-1:0]  mem_waddr
);
  // R7: a write strobe follows only an accepted store
  a_r7_we_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(req_valid && req_ready && req_store));

  // R6: a misaligned access never writes
  a_r6_we_not_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rsp_misalign);

  // R8: a stalled response holds its payload
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_misalign)));

  // R8: a stalled response blocks new requests
  a_r8_stall_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R1: the write goes to the word address shown at acceptance
  a_r1_waddr_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr == $past(mem_raddr)));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_store    (req_store),
  .mem_raddr    (mem_raddr),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_misalign (rsp_misalign),
  .mem_we       (mem_we),
  .mem_waddr    (mem_waddr)
);

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_sext = 1'b0;
  logic [31:0] req_base = '0;
  logic [11:0] req_imm = '0;
  logic [31:0] req_wdata = '0;
  logic [29:0] mem_raddr;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_misalign;
  logic        mem_we;
  logic [29:0] mem_waddr;
  logic [31:0] mem_wdata;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  lsu_lane_align u_lsu_lane_align (.*);

  function automatic logic [31:0] f_addr(logic [31:0] b, logic [11:0] i);
    return b + {{20{i[11]}}, i};
  endfunction

  function automatic int f_nb(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic f_mis(logic [31:0] a, logic [1:0] s);
    return (int'(a[1:0]) + f_nb(s)) > 4;
  endfunction

  function automatic logic [31:0] f_load(logic [31:0] rd, logic [31:0] a,
                                         logic [1:0] s, logic sx);
    logic [31:0] v;
    int n;
    n = f_nb(s);
    if (f_mis(a, s)) return 32'd0;
    v = rd >> (8 * a[1:0]);
    if (n == 1) v = sx ? {{24{v[7]}}, v[7:0]} : {24'd0, v[7:0]};
    else if (n == 2) v = sx ? {{16{v[15]}}, v[15:0]} : {16'd0, v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] f_merge(logic [31:0] wd, logic [31:0] old,
                                          logic [31:0] a, logic [1:0] s);
    logic [31:0] m;
    m = (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return ((wd & m) << (8 * a[1:0])) | (old & ~(m << (8 * a[1:0])));
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic st, logic [1:0] sz, logic sx, logic [31:0] b,
                       logic [11:0] i, logic [31:0] wd, logic [31:0] rd);
    req_valid = 1'b1; req_store = st; req_size = sz; req_sext = sx;
    req_base = b; req_imm = i; req_wdata = wd; mem_rdata = rd;
  endtask

  // One request with rsp_ready high; called at a negedge.
  task automatic do_req(logic st, logic [1:0] sz, logic sx, logic [31:0] b,
                        logic [11:0] i, logic [31:0] wd, logic [31:0] rd, string req);
    logic [31:0] a;
    logic mis;
    a = f_addr(b, i);
    mis = f_mis(a, sz);
    drive(st, sz, sx, b, i, wd, rd);
    #1;
    chk(mem_raddr == a[31:2], "R1 raddr", {2'b0, mem_raddr}, {2'b0, a[31:2]});
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_misalign == mis, "R6 misalign", {31'd0, rsp_misalign}, {31'd0, mis});
    if (!st) begin
      chk(rsp_data == f_load(rd, a, sz, sx), req, rsp_data, f_load(rd, a, sz, sx));
      chk(mem_we == 1'b0, "R7 no we on load", {31'd0, mem_we}, 32'd0);
    end else begin
      chk(mem_we == !mis, mis ? "R6 no we" : "R7 we", {31'd0, mem_we}, {31'd0, !mis});
      if (!mis) begin
        chk(mem_wdata == f_merge(wd, rd, a, sz), req, mem_wdata, f_merge(wd, rd, a, sz));
        chk(mem_waddr == a[31:2], "R1 waddr", {2'b0, mem_waddr}, {2'b0, a[31:2]});
      end
    end
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(mem_we == 1'b0, "R7 single pulse", {31'd0, mem_we}, 32'd0);
    chk(rsp_valid == 1'b0, "R8 rsp taken", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a_exp;
    logic [31:0] b_exp;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(rsp_valid == 1'b0, "R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(mem_we == 1'b0, "R9 mem_we", {31'd0, mem_we}, 32'd0);
    chk(req_ready == 1'b1, "R9 req_ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: byte loads at each offset, signed and unsigned
    for (int k = 0; k < 4; k++) begin
      do_req(1'b0, 2'd0, 1'b1, 32'h0000_1000 + k, 12'h000, '0, 32'h80F1_7F82, "R2 byte signed");
      do_req(1'b0, 2'd0, 1'b0, 32'h0000_1000 + k, 12'h000, '0, 32'h80F1_7F82, "R2 byte zero");
    end
    // R3: halfword loads at offsets 0..2
    for (int k = 0; k < 3; k++)
      do_req(1'b0, 2'd1, 1'b1, 32'h0000_2000, 12'(k), '0, 32'h7FFF_8001, "R3 half signed");
    do_req(1'b0, 2'd1, 1'b0, 32'h0000_2001, 12'h000, '0, 32'h12F3_4456, "R3 half zero");
    // R4: full word, both extension modes
    do_req(1'b0, 2'd2, 1'b1, 32'h0000_3000, 12'h000, '0, 32'hDEAD_BEEF, "R4 word");
    do_req(1'b0, 2'd2, 1'b0, 32'h0000_3000, 12'h000, '0, 32'hDEAD_BEEF, "R4 word");
    // R10: size code 3 acts as a word
    do_req(1'b0, 2'd3, 1'b1, 32'h0000_3004, 12'h000, '0, 32'h9ABC_DEF0, "R10 word alias");
    do_req(1'b1, 2'd3, 1'b0, 32'h0000_3008, 12'h000, 32'h1122_3344, 32'hAAAA_AAAA, "R10 store alias");
    do_req(1'b0, 2'd3, 1'b0, 32'h0000_3001, 12'h000, '0, 32'h9ABC_DEF0, "R10 misalign alias");
    // R6: misaligned halfword and words
    do_req(1'b0, 2'd1, 1'b1, 32'h0000_4003, 12'h000, '0, 32'hFFFF_FFFF, "R6 half ofs3 load");
    do_req(1'b1, 2'd1, 1'b0, 32'h0000_4003, 12'h000, 32'h5555, 32'h0, "R6 half ofs3 store");
    do_req(1'b1, 2'd2, 1'b0, 32'h0000_4002, 12'h000, 32'h5555, 32'h0, "R6 word ofs2 store");
    // R5: byte and halfword merges, negative immediate (R1)
    do_req(1'b1, 2'd0, 1'b0, 32'h0000_5010, 12'hFF3, 32'hFFFF_FFA5, 32'h0102_0304, "R5 byte merge");
    do_req(1'b1, 2'd1, 1'b0, 32'h0000_5012, 12'h000, 32'hFFFF_BEEF, 32'h0102_0304, "R5 half merge");
    do_req(1'b1, 2'd2, 1'b0, 32'h0000_5014, 12'h000, 32'hCAFE_F00D, 32'h0102_0304, "R5 word store");

    // R8: stalled response holds and blocks the next request
    rsp_ready = 1'b0;
    drive(1'b0, 2'd0, 1'b1, 32'h0000_6001, 12'h000, '0, 32'h0000_8000);
    a_exp = f_load(32'h0000_8000, 32'h0000_6001, 2'd0, 1'b1);
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 2'd1, 1'b0, 32'h0000_6002, 12'h000, '0, 32'hABCD_0000);
    b_exp = f_load(32'hABCD_0000, 32'h0000_6002, 2'd1, 1'b0);
    #1;
    chk(req_ready == 1'b0, "R8 stall blocks", {31'd0, req_ready}, 32'd0);
    chk(rsp_data == a_exp, "R2 stalled byte", rsp_data, a_exp);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 still valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_data == a_exp, "R8 data held", rsp_data, a_exp);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R8 ready returns", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 next rsp", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_data == b_exp, "R3 second rsp", rsp_data, b_exp);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rb;
      logic [11:0] ri;
      logic [1:0] rs;
      rb = $urandom;
      ri = 12'($urandom);
      rs = 2'($urandom);
      if ($urandom % 2 == 0)
        do_req(1'b0, rs, 1'($urandom), rb, ri, $urandom, $urandom, "R2 R3 R4 random load");
      else
        do_req(1'b1, rs, 1'b0, rb, ri, $urandom, $urandom, "R5 random store");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule